// File: doc/BRIEF.md
# Parameterized Streaming CRC Engine

This block computes a cyclic redundancy check over a stream of data words. Everything that defines the CRC is a build-time parameter: the generator polynomial, the value the register starts from, the value XORed onto the finished result, and two bit-order options. One option sets whether each input word is consumed from its top or its bottom bit. The other sets whether the result register is bit-reversed before the final XOR. The word width is also a parameter and may be as small as one bit. The same design therefore serves as a bit-serial, nibble-wide or byte-wide CRC, and it gives the same checksum for the same bit stream.

A frame is processed in three steps. A start pulse reloads the register. Each cycle with valid high then folds one word into the register, with no stall. A finish request then produces the finished checksum on the following cycle, together with a one-cycle done flag. After a finish, the engine ignores further words and finish requests until the next start. A start in the same cycle as a valid word reloads the register first and then folds that word in.

Top module: `crc_stream`

## Requirements
- R1: Reset clears `crc_o` to zero and `done_o` to low, loads the register with the initial value and leaves the engine accepting words, so a frame sent after reset without a start pulse gives the correct checksum.
- R2: A start pulse with valid low loads the initial value. A finish that follows with no words in between returns the finalized initial value (0x0000 for the CRC-16 configuration below).
- R3: With input reflection off, bit DATA_W-1 of each word enters the register first. With it on, bit 0 enters first.
- R4: At finish, the register is bit-reversed when output reflection is on (bit i moves to bit CRC_W-1-i) and is then XORed with the final value.
- R5: Each cycle with valid high absorbs exactly one word. Idle cycles between words, of any number, do not change the result.
- R6: For the same bit stream, a build with DATA_W=1 returns the same checksum as a byte-wide build. With input reflection on, the bits of each byte are sent least significant bit first.
- R7: The configuration with polynomial 0x8005, initial value 0xFFFF, final XOR 0xFFFF and both reflections on returns 0xB4C8 for the ASCII string "123456789". The configuration with polynomial 0x07, zero initial value, zero final XOR and no reflection returns 0xF4 for the same string.
- R8: A finish while accepting puts the checksum on `crc_o` and raises `done_o` on the next cycle, for one cycle. A word that is valid in the same cycle as the finish is included. `crc_o` holds its value at all other times.
- R9: After a finish, valid words and finish requests have no effect until a start: `done_o` stays low and `crc_o` keeps its value.
- R10: A start together with valid discards the frame in progress, reloads the initial value and absorbs that word as the first word of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Reload the register and open a new frame |
| data_i | input | DATA_W | Data word |
| valid_i | input | 1 | `data_i` carries a word this cycle |
| finish_i | input | 1 | Close the frame and produce the checksum |
| crc_o | output | CRC_W | Finished checksum, held until the next finish |
| done_o | output | 1 | One-cycle pulse when `crc_o` is updated |

## Verification
The hardest case to reach from the ports is a start that lands in the middle of a frame together with a valid word. Only the data after that point may count, and nothing on the outputs shows when the discarded part is dropped. The bench reaches this case by sending a few random words without finishing, then opening a new frame on a random message whose first word carries the start. It compares the result against a bit-serial model of the new message alone. Random frame lengths, idle gaps and finish placement, mirrored on a one-bit build, also show that chunk width and timing never change the checksum.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;

   // Frame phase: accepting words, or closed after a finish.
   typedef enum logic {
      PH_OPEN   = 1'b0,
      PH_CLOSED = 1'b1
   } crc_phase_e;

   // Widest register the engine is meant to be built with.
   localparam int unsigned CRC_MAX_W = 64;

endpackage

// File: rtl/crc_word_order.sv
// Puts the bit that must enter the register first at the top of the word.
module crc_word_order #(
   parameter int unsigned DATA_W  = 8,
   parameter bit          REFLECT = 1'b0
) (
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] word_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("crc_word_order: DATA_W must be at least 1");
   end

   if (REFLECT) begin : g_reverse
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign word_o[i] = word_i[DATA_W-1-i];
      end
   end else begin : g_straight
      assign word_o = word_i;
   end

endmodule

// File: rtl/crc_unroll.sv
// Folds a whole word into the CRC register, one shift stage per data bit.
module crc_unroll #(
   parameter int unsigned          CRC_W  = 16,
   parameter int unsigned          DATA_W = 8,
   parameter logic [CRC_W-1:0]     POLY   = 16'h8005
) (
   input  logic [CRC_W-1:0]  state_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [CRC_W-1:0]  state_o
);

   if (DATA_W < 1) begin : g_bad_data
      $error("crc_unroll: DATA_W must be at least 1");
   end
   if (CRC_W < 1) begin : g_bad_crc
      $error("crc_unroll: CRC_W must be at least 1");
   end

   logic [DATA_W:0][CRC_W-1:0] chain;

   assign chain[0] = state_i;

   for (genvar k = 0; k < DATA_W; k++) begin : g_stage
      logic fb;
      assign fb           = chain[k][CRC_W-1] ^ word_i[DATA_W-1-k];
      assign chain[k+1]   = (chain[k] << 1) ^ (fb ? POLY : '0);
   end

   assign state_o = chain[DATA_W];

endmodule

// File: rtl/crc_finalize.sv
// Optional bit reversal of the register followed by the final XOR.
module crc_finalize #(
   parameter int unsigned      CRC_W   = 16,
   parameter logic [CRC_W-1:0] XOR_OUT = 16'hFFFF,
   parameter bit               REFLECT = 1'b1
) (
   input  logic [CRC_W-1:0] state_i,
   output logic [CRC_W-1:0] crc_o
);

   logic [CRC_W-1:0] ordered;

   if (REFLECT) begin : g_reverse
      for (genvar i = 0; i < CRC_W; i++) begin : g_bit
         assign ordered[i] = state_i[CRC_W-1-i];
      end
   end else begin : g_straight
      assign ordered = state_i;
   end

   assign crc_o = ordered ^ XOR_OUT;

endmodule

// File: rtl/crc_stream.sv
module crc_stream
   import crc_stream_pkg::*;
#(
   parameter int unsigned      CRC_W       = 16,
   parameter int unsigned      DATA_W      = 8,
   parameter logic [CRC_W-1:0] POLY        = 16'h8005,
   parameter logic [CRC_W-1:0] INIT        = 16'hFFFF,
   parameter logic [CRC_W-1:0] XOR_OUT     = 16'hFFFF,
   parameter bit               REFLECT_IN  = 1'b1,
   parameter bit               REFLECT_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   input  logic              finish_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              done_o
);

   if (CRC_W < 1 || CRC_W > CRC_MAX_W) begin : g_bad_crc_w
      $error("crc_stream: CRC_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("crc_stream: DATA_W must be at least 1");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("crc_stream: generator polynomial needs its constant term");
   end

   crc_phase_e       phase_q;
   logic [CRC_W-1:0] state_q;
   logic [CRC_W-1:0] state_base;
   logic [CRC_W-1:0] state_step;
   logic [CRC_W-1:0] state_next;
   logic [CRC_W-1:0] crc_final;
   logic [CRC_W-1:0] crc_q;
   logic             done_q;
   logic [DATA_W-1:0] word_ordered;
   logic             accepting;
   logic             absorb;
   logic             close_now;

   // A start takes effect before the word that arrives with it.
   assign accepting  = start_i | (phase_q == PH_OPEN);
   assign absorb     = valid_i & accepting;
   assign close_now  = finish_i & accepting;
   assign state_base = start_i ? INIT : state_q;
   assign state_next = absorb ? state_step : state_base;

   crc_word_order #(
      .DATA_W  (DATA_W),
      .REFLECT (REFLECT_IN)
   ) u_order (
      .word_i (data_i),
      .word_o (word_ordered)
   );

   crc_unroll #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W),
      .POLY   (POLY)
   ) u_unroll (
      .state_i (state_base),
      .word_i  (word_ordered),
      .state_o (state_step)
   );

   // Finalize from the next state so a word alongside finish is included.
   crc_finalize #(
      .CRC_W   (CRC_W),
      .XOR_OUT (XOR_OUT),
      .REFLECT (REFLECT_OUT)
   ) u_final (
      .state_i (state_next),
      .crc_o   (crc_final)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= INIT;
         phase_q <= PH_OPEN;
         crc_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_next;
         done_q  <= close_now;
         if (close_now) begin
            crc_q   <= crc_final;
            phase_q <= PH_CLOSED;
         end else if (start_i) begin
            phase_q <= PH_OPEN;
         end
      end
   end

   assign crc_o  = crc_q;
   assign done_o = done_q;

   // R8: a done pulse is always the answer to a finish request
   assert_done_after_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(finish_i));

   // R8: the result only moves together with done
   assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(crc_o));

   // R9: a closed frame keeps its register while no start arrives
   assert_closed_state_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CLOSED && !start_i) |=> $stable(state_q));

   // R9: a closed frame cannot produce done without a start
   assert_closed_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CLOSED && !start_i) |=> !done_o);

   // R2: a start without data leaves the initial value in the register
   assert_start_loads_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_i) |=> (state_q == INIT));

   // R5: idle cycles leave the register untouched
   assert_idle_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !start_i) |=> $stable(state_q));

endmodule

// File: tb/crc_stream_tb.sv
`timescale 1ns/1ps
module crc_stream_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   // Instance A: CRC-16 byte-wide, both reflections on
   logic        s_a = 0, v_a = 0, f_a = 0;
   logic [7:0]  d_a = '0;
   logic [15:0] crc_a;
   logic        done_a;
   // Instance B: same CRC, one bit per word
   logic        s_b = 0, v_b = 0, f_b = 0;
   logic [0:0]  d_b = '0;
   logic [15:0] crc_b;
   logic        done_b;
   // Instance N: CRC-8, no reflection
   logic        s_n = 0, v_n = 0, f_n = 0;
   logic [7:0]  d_n = '0;
   logic [7:0]  crc_n;
   logic        done_n;

   crc_stream #(.CRC_W(16), .DATA_W(8), .POLY(16'h8005), .INIT(16'hFFFF),
      .XOR_OUT(16'hFFFF), .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(s_a), .data_i(d_a), .valid_i(v_a),
      .finish_i(f_a), .crc_o(crc_a), .done_o(done_a));

   crc_stream #(.CRC_W(16), .DATA_W(1), .POLY(16'h8005), .INIT(16'hFFFF),
      .XOR_OUT(16'hFFFF), .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1)) u_dut_bit (
      .clk(clk), .rst_n(rst_n), .start_i(s_b), .data_i(d_b), .valid_i(v_b),
      .finish_i(f_b), .crc_o(crc_b), .done_o(done_b));

   crc_stream #(.CRC_W(8), .DATA_W(8), .POLY(8'h07), .INIT(8'h00),
      .XOR_OUT(8'h00), .REFLECT_IN(1'b0), .REFLECT_OUT(1'b0)) u_dut_plain (
      .clk(clk), .rst_n(rst_n), .start_i(s_n), .data_i(d_n), .valid_i(v_n),
      .finish_i(f_n), .crc_o(crc_n), .done_o(done_n));

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [7:0] msg [0:63];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Bit-serial model of the requirements (R3, R4)
   function automatic logic [31:0] model(input int n, input int w, input logic [31:0] poly,
      input logic [31:0] init, input logic [31:0] xo, input bit ri, input bit ro);
      logic [31:0] mask = (32'h1 << w) - 1;
      logic [31:0] r = init & mask;
      logic [31:0] o = '0;
      for (int b = 0; b < n; b++) begin
         for (int j = 0; j < 8; j++) begin
            logic bt, fb;
            bt = ri ? msg[b][j] : msg[b][7-j];
            fb = r[w-1] ^ bt;
            r  = (r << 1) & mask;
            if (fb) r = r ^ poly;
         end
      end
      if (ro) begin
         for (int i = 0; i < w; i++) o[i] = r[w-1-i];
         r = o;
      end
      return (r ^ xo) & mask;
   endfunction

   function automatic logic [31:0] expect_for(input int sel, input int n);
      if (sel == 2) return model(n, 8, 32'h07, 32'h00, 32'h00, 1'b0, 1'b0);
      return model(n, 16, 32'h8005, 32'hFFFF, 32'hFFFF, 1'b1, 1'b1);
   endfunction

   task automatic drive(input int sel, input bit s, input bit v, input logic [7:0] d,
                        input bit f);
      case (sel)
         0: begin s_a = s; v_a = v; d_a = d; f_a = f; end
         1: begin s_b = s; v_b = v; d_b = d[0]; f_b = f; end
         default: begin s_n = s; v_n = v; d_n = d; f_n = f; end
      endcase
   endtask

   function automatic logic [15:0] get_crc(input int sel);
      if (sel == 0) return crc_a;
      if (sel == 1) return crc_b;
      return {8'h00, crc_n};
   endfunction

   function automatic bit get_done(input int sel);
      if (sel == 0) return done_a;
      if (sel == 1) return done_b;
      return done_n;
   endfunction

   // Send msg[0..n-1] and check the result and the done pulse.
   task automatic run_msg(input int sel, input int n, input bit use_start,
                          input bit fin_last, input bit gaps, input string req);
      int units = (sel == 1) ? 8 : 1;
      logic [31:0] exp = expect_for(sel, n);
      if (n == 0) begin
         @(negedge clk); drive(sel, 1, 0, 8'h00, 0);
         @(negedge clk); drive(sel, 0, 0, 8'h00, 1);
      end else begin
         for (int b = 0; b < n; b++) begin
            for (int u = 0; u < units; u++) begin
               bit first = (b == 0) && (u == 0);
               bit last  = (b == n - 1) && (u == units - 1);
               logic [7:0] dat = (sel == 1) ? {7'b0, msg[b][u]} : msg[b];
               @(negedge clk);
               if (gaps && ($urandom % 4 == 0)) begin
                  drive(sel, 0, 0, 8'h00, 0);
                  @(negedge clk);
               end
               drive(sel, first && use_start, 1, dat, last && fin_last);
            end
         end
         if (!fin_last) begin
            @(negedge clk); drive(sel, 0, 0, 8'h00, 1);
         end
      end
      @(negedge clk);
      drive(sel, 0, 0, 8'h00, 0);
      check(get_done(sel) == 1'b1, {req, " done pulse"}, 32'(get_done(sel)), 32'd1);
      check(get_crc(sel) == exp[15:0], req, 32'(get_crc(sel)), exp);
      @(negedge clk);
      check(get_done(sel) == 1'b0, "R8 done lasts one cycle", 32'(get_done(sel)), 32'd0);
   endtask

   task automatic load_check_string();
      string s = "123456789";
      for (int i = 0; i < 9; i++) msg[i] = s[i];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] saved;
      process::self().srandom(32'd7741);
      repeat (3) @(negedge clk);
      // R1: reset values
      check(crc_a == 16'h0 && done_a == 1'b0, "R1 reset outputs", {crc_a, 15'b0, done_a}, 32'd0);
      check(crc_n == 8'h0 && done_n == 1'b0, "R1 reset outputs plain", {crc_n, 7'b0, done_n}, 32'd0);
      rst_n = 1'b1;

      // R1: frame after reset with no start pulse
      load_check_string();
      run_msg(0, 9, 1'b0, 1'b1, 1'b0, "R1 no-start frame");
      // R7: standard check values
      run_msg(0, 9, 1'b1, 1'b0, 1'b0, "R7 CRC-16 check string");
      check(crc_a == 16'hB4C8, "R7 CRC-16 constant", 32'(crc_a), 32'hB4C8);
      run_msg(2, 9, 1'b1, 1'b1, 1'b0, "R7 R3 CRC-8 check string");
      check(crc_n == 8'hF4, "R7 CRC-8 constant", 32'(crc_n), 32'hF4);
      // R6: bit-serial build on the same stream
      run_msg(1, 9, 1'b1, 1'b1, 1'b0, "R6 one-bit build");
      check(crc_b == 16'hB4C8, "R6 one-bit constant", 32'(crc_b), 32'hB4C8);
      // R2: empty frame
      run_msg(0, 0, 1'b1, 1'b0, 1'b0, "R2 empty frame");
      check(crc_a == 16'h0000, "R2 finalized init", 32'(crc_a), 32'h0);

      // R9: data and finish after a finish are ignored
      saved = crc_a;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(done_a == 1'b0, "R9 no done while closed", 32'(done_a), 32'd0);
         drive(0, 0, 1, 8'($urandom), (k % 2) == 1);
      end
      @(negedge clk);
      drive(0, 0, 0, 8'h00, 0);
      check(done_a == 1'b0, "R9 no done while closed", 32'(done_a), 32'd0);
      check(crc_a == saved, "R9 result unchanged", 32'(crc_a), 32'(saved));

      // Random frames on all three builds (R3, R4, R5, R6, R8)
      for (int it = 0; it < 40; it++) begin
         int n = 1 + ($urandom % 16);
         bit fl = $urandom % 2;
         for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
         run_msg(0, n, 1'b1, fl, 1'b1, "R3 R4 R5 R8 random byte frame");
         run_msg(1, n, 1'b1, fl, 1'b1, "R6 random bit-serial frame");
         run_msg(2, n, 1'b1, fl, 1'b1, "R3 random plain frame");
      end

      // R10: restart mid-frame with start and valid together
      for (int it = 0; it < 6; it++) begin
         int n = 1 + ($urandom % 10);
         int sel = (it % 2 == 0) ? 0 : 2;
         for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            drive(sel, j == 0, 1, 8'($urandom), 0);
         end
         for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
         run_msg(sel, n, 1'b1, 1'b1, 1'b0, "R10 restart with data");
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule